// File: doc/BRIEF.md
# Level-Sensitive Latch Emulator on a Single Global Clock

This block reproduces the behaviour of a level-sensitive D latch, with optional per-bit asynchronous-style set and clear, inside a design where every storage element is clocked by one global clock. A register on that clock keeps a copy of the output from the previous cycle. While the enable sits at its active level, the output passes the data input straight through with no register on the path. While the enable is inactive, the output returns the stored copy. Set and clear then act on the result bit by bit, and clear takes priority.

It is meant for flows that must turn latch-based logic into plain edge-triggered logic, such as formal models or single-clock emulation. Every polarity is a parameter. A reset value can be given for any subset of the stored bits. The data path is a plain level interface with no valid/ready handshake, because a latch has no notion of transfers or back-pressure. The output is valid in every cycle and follows its inputs combinationally.

Top module: `latch_emu`

## Requirements
- R1: While the enable is active and no set or clear bit is active, `q_o` equals `d_i` in the same cycle, with no clock edge in between.
- R2: While the enable is inactive and no set or clear bit is active, `q_o` equals the value `q_o` had just before the most recent rising edge of `clk`.
- R3: With `EN_ACT_HIGH`=1 the enable is active when `en_i`=1. With `EN_ACT_HIGH`=0 it is active when `en_i`=0.
- R4: With `USE_SET_CLR`=1, every bit whose set input is active and whose clear input is inactive reads 1 on `q_o`, whatever the enable or data.
- R5: With `USE_SET_CLR`=1, every bit whose clear input is active reads 0 on `q_o`, even when its set input is also active.
- R6: Set bit i is active when `set_i[i]` equals `SET_ACT_HIGH`. Clear bit i is active when `clr_i[i]` equals `CLR_ACT_HIGH`.
- R7: With `USE_SET_CLR`=0, `set_i` and `clr_i` have no effect on `q_o`.
- R8: While `rst_n` is low, each stored bit i with `INIT_MASK[i]`=1 holds `INIT_VAL[i]`, so with the enable inactive and no set or clear active, those bits of `q_o` show `INIT_VAL`. Bits with `INIT_MASK[i]`=0 are not reset and have no defined power-up value.
- R9: Each bit is handled on its own: bits that hold, bits that are set and bits that are cleared can all appear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock; the stored copy of `q_o` updates on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for the stored bits selected by `INIT_MASK` |
| en_i | input | 1 | Latch enable; its active level is set by `EN_ACT_HIGH` |
| d_i | input | W | Data input |
| set_i | input | W | Per-bit set; active level set by `SET_ACT_HIGH` |
| clr_i | input | W | Per-bit clear; active level set by `CLR_ACT_HIGH`; overrides set |
| q_o | output | W | Latch output |

## Verification
The bench builds three instances with `W`=8. The first uses active-high enable, set and clear with set/clear enabled and a full reset value. This puts transparency, hold, set, clear priority and mixed per-bit cases within reach. The second inverts all three polarities and resets only the low nibble, which covers the swapped mux inputs, inverted set/clear decoding and partial reset. The third turns set/clear off, so that the bench can show at the output that those pins are ignored.

// File: rtl/latch_emu_pkg.sv
package latch_emu_pkg;

  // Returns 1 when a level input equals its configured active level.
  function automatic logic lvl_active(input logic sig, input bit act_high);
    return act_high ? sig : ~sig;
  endfunction

endpackage

// File: rtl/latch_emu_pol.sv
module latch_emu_pol #(
  parameter int W         = 8,
  parameter bit ACT_HIGH  = 1'b1
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] act_o
);
  import latch_emu_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb act_o[i] = lvl_active(raw_i[i], ACT_HIGH);
  end
endmodule

// File: rtl/latch_emu_state.sv
module latch_emu_state #(
  parameter int         W         = 8,
  parameter logic [W-1:0] INIT_VAL  = '0,
  parameter logic [W-1:0] INIT_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] prev_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st_b;
    if (INIT_MASK[i]) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_b <= INIT_VAL[i];
        else        st_b <= nxt_i[i];
      end
    end else begin : g_free
      always_ff @(posedge clk) st_b <= nxt_i[i];
    end
    assign prev_o[i] = st_b;
  end
endmodule

// File: rtl/latch_emu_core.sv
module latch_emu_core #(
  parameter int W           = 8,
  parameter bit USE_SET_CLR = 1'b1
) (
  input  logic         en_act_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] set_act_i,
  input  logic [W-1:0] clr_act_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pick;

  for (genvar i = 0; i < W; i++) begin : g_mux
    always_comb pick[i] = en_act_i ? d_i[i] : prev_i[i];
  end

  if (USE_SET_CLR) begin : g_sc
    always_comb q_o = (pick | set_act_i) & ~clr_act_i;
  end else begin : g_plain
    always_comb q_o = pick;
  end
endmodule

// File: rtl/latch_emu.sv
module latch_emu #(
  parameter int           W            = 8,
  parameter bit           EN_ACT_HIGH  = 1'b1,
  parameter bit           USE_SET_CLR  = 1'b1,
  parameter bit           SET_ACT_HIGH = 1'b1,
  parameter bit           CLR_ACT_HIGH = 1'b1,
  parameter logic [W-1:0] INIT_VAL     = '0,
  parameter logic [W-1:0] INIT_MASK    = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  import latch_emu_pkg::*;

  logic         en_act;
  logic [W-1:0] set_act, clr_act, prev_q;

  always_comb en_act = lvl_active(en_i, EN_ACT_HIGH);

  latch_emu_pol #(.W(W), .ACT_HIGH(SET_ACT_HIGH)) u_set_pol (
    .raw_i(set_i), .act_o(set_act));

  latch_emu_pol #(.W(W), .ACT_HIGH(CLR_ACT_HIGH)) u_clr_pol (
    .raw_i(clr_i), .act_o(clr_act));

  latch_emu_state #(.W(W), .INIT_VAL(INIT_VAL), .INIT_MASK(INIT_MASK)) u_state (
    .clk(clk), .rst_n(rst_n), .nxt_i(q_o), .prev_o(prev_q));

  latch_emu_core #(.W(W), .USE_SET_CLR(USE_SET_CLR)) u_core (
    .en_act_i(en_act), .d_i(d_i), .prev_i(prev_q),
    .set_act_i(set_act), .clr_act_i(clr_act), .q_o(q_o));
endmodule

// File: rtl/latch_emu_chk.sv
module latch_emu_chk #(
  parameter int W            = 8,
  parameter bit EN_ACT_HIGH  = 1'b1,
  parameter bit USE_SET_CLR  = 1'b1,
  parameter bit SET_ACT_HIGH = 1'b1,
  parameter bit CLR_ACT_HIGH = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_i,
  input logic [W-1:0] d_i,
  input logic [W-1:0] set_i,
  input logic [W-1:0] clr_i,
  input logic [W-1:0] q_o
);
  logic         en_on;
  logic [W-1:0] s_on, c_on;
  logic         quiet;

  always_comb begin
    en_on = (en_i == EN_ACT_HIGH);
    s_on  = USE_SET_CLR ? (SET_ACT_HIGH ? set_i : ~set_i) : '0;
    c_on  = USE_SET_CLR ? (CLR_ACT_HIGH ? clr_i : ~clr_i) : '0;
    quiet = (s_on == '0) && (c_on == '0);
  end

  // R1 / R3: transparent path
  assert_transparent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_on && quiet) |-> (q_o == d_i));

  // R2: hold returns the output seen at the previous edge
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_on && quiet && $past(rst_n)) |-> (q_o == $past(q_o)));

  // R4: active set without clear drives 1
  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_on & ~c_on) != '0) |-> ((q_o & s_on & ~c_on) == (s_on & ~c_on)));

  // R5: clear always drives 0
  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_on != '0) |-> ((q_o & c_on) == '0));
endmodule

bind latch_emu latch_emu_chk #(
  .W(W), .EN_ACT_HIGH(EN_ACT_HIGH), .USE_SET_CLR(USE_SET_CLR),
  .SET_ACT_HIGH(SET_ACT_HIGH), .CLR_ACT_HIGH(CLR_ACT_HIGH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .d_i(d_i),
  .set_i(set_i), .clr_i(clr_i), .q_o(q_o));

// File: tb/latch_emu_tb_top.sv
module latch_emu_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] d = '0, s = '0, c = '0;
  logic [W-1:0] q_hi, q_lo, q_ns;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  latch_emu #(.W(W), .INIT_VAL(8'hA5), .INIT_MASK(8'hFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .d_i(d), .set_i(s), .clr_i(c), .q_o(q_hi));

  latch_emu #(.W(W), .EN_ACT_HIGH(1'b0), .SET_ACT_HIGH(1'b0), .CLR_ACT_HIGH(1'b0),
              .INIT_VAL(8'h3C), .INIT_MASK(8'h0F)) dut_lo_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .d_i(d), .set_i(s), .clr_i(c), .q_o(q_lo));

  latch_emu #(.W(W), .USE_SET_CLR(1'b0), .INIT_VAL(8'h00), .INIT_MASK(8'hFF)) dut_ns_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .d_i(d), .set_i(s), .clr_i(c), .q_o(q_ns));

  // {en, d, set, clr, expected q} for dut_i, one row per cycle
  localparam logic [32:0] TBL [9] = '{
    {1'b1, 8'h3C, 8'h00, 8'h00, 8'h3C},  // R1 pass-through
    {1'b0, 8'hFF, 8'h00, 8'h00, 8'h3C},  // R2 hold
    {1'b0, 8'h00, 8'h03, 8'h00, 8'h3F},  // R4 set
    {1'b0, 8'h00, 8'h00, 8'h0F, 8'h30},  // R5 clear
    {1'b0, 8'h00, 8'hF0, 8'hF0, 8'h00},  // R5 clear beats set
    {1'b0, 8'hAA, 8'h00, 8'h00, 8'h00},  // R2 hold after clear
    {1'b1, 8'hAA, 8'h01, 8'h80, 8'h2B},  // R9 mixed bits
    {1'b0, 8'h55, 8'h00, 8'h00, 8'h2B},  // R2 hold
    {1'b1, 8'h55, 8'h00, 8'h00, 8'h55}   // R3 active-high enable
  };

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp, input logic [W-1:0] msk);
    checks++;
    if ((act & msk) !== (exp & msk)) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (mask %h)", req, act, exp, msk);
    end
  endtask

  task automatic drive(input logic e, input logic [W-1:0] dv,
                       input logic [W-1:0] sv, input logic [W-1:0] cv);
    @(negedge clk);
    en = e; d = dv; s = sv; c = cv;
    #1;
  endtask

  initial begin
    // R8: reset state, enable inactive for dut_i and dut_ns_i
    #25;
    chk("R8 reset value", q_hi, 8'hA5, 8'hFF);
    chk("R8 reset value no-setclr", q_ns, 8'h00, 8'hFF);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < 9; k++) begin
      drive(TBL[k][32], TBL[k][31:24], TBL[k][23:16], TBL[k][15:8]);
      chk($sformatf("R1/R2/R4/R5/R9 table row %0d", k), q_hi, TBL[k][7:0], 8'hFF);
    end

    // R8: partial reset on inverted instance (en=1 inactive, set/clr idle high)
    drive(1'b1, 8'h00, 8'hFF, 8'hFF);
    rst_n = 1'b0; #1;
    chk("R8 partial reset low nibble", q_lo, 8'h0C, 8'h0F);
    drive(1'b0, 8'h5A, 8'hFF, 8'hFF);
    rst_n = 1'b1; #1;
    chk("R3 active-low enable passes data", q_lo, 8'h5A, 8'hFF);
    drive(1'b1, 8'h00, 8'hFF, 8'hFF);
    chk("R3 active-low enable holds", q_lo, 8'h5A, 8'hFF);
    drive(1'b1, 8'h00, 8'hF0, 8'hFF);
    chk("R6 active-low set", q_lo, 8'h5F, 8'hFF);
    drive(1'b1, 8'h00, 8'hF0, 8'h3F);
    chk("R6 active-low clear wins", q_lo, 8'h1F, 8'hFF);

    // R7: set/clear ignored when disabled
    drive(1'b1, 8'h81, 8'hFF, 8'hFF);
    chk("R7 set/clear ignored, transparent", q_ns, 8'h81, 8'hFF);
    drive(1'b0, 8'h00, 8'hFF, 8'hFF);
    chk("R7 set/clear ignored, hold", q_ns, 8'h81, 8'hFF);
    drive(1'b0, 8'h00, 8'h00, 8'h00);
    chk("R2 hold no-setclr", q_ns, 8'h81, 8'hFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule